// File: doc/BRIEF.md
# Reset and Interrupt Vector Fetch Sequencer

This block sits beside a small processor core and takes care of one task: when the core leaves reset, or when an interrupt is accepted, it reads a 16-bit handler address out of a fixed four-entry table at the top of a 64 KB memory space. It then hands that address to the program counter. It serves four sources: reset, a non-maskable interrupt, a software interrupt raised by the core's decode logic, and a maskable interrupt that is gated by an interrupt mask flag held in this block.

Each table entry takes two bytes. The byte at the even address is the upper half of the handler address, and the byte at the following odd address is the lower half. The block reads the two bytes one after the other over a simple request/ready memory port, with the even byte first. Each read stays posted until the memory answers. Once both bytes are in, the block gives a one-cycle load strobe together with the assembled address and the code of the source it served. Accepting any source sets the mask flag. The core clears the flag with a one-cycle strobe.

Top module: `vector_fetch_seq`

## Requirements
- R1: After synchronous reset is released, the block starts a fetch of the reset vector without any other stimulus, and it loads the program counter with the bytes at 0xFFFE (upper) and 0xFFFF (lower).
- R2: Source codes on `pc_src` are reset=3, non-maskable=2, software=1, maskable=0. The table entry of code c begins at address 0xFFF8 + 2*c, so every memory request addresses the range 0xFFF8..0xFFFF.
- R3: For each fetch, the even address is read first and supplies bits 15:8. The odd address is read second and supplies bits 7:0.
- R4: A read keeps `mem_req` high and `mem_addr` unchanged until `mem_ready` is seen high on a clock edge. Any number of wait cycles is tolerated.
- R5: `pc_load` is high for exactly one cycle per fetch, in the cycle after the second read completes. `pc_value` and `pc_src` are valid in that cycle.
- R6: A low level on `irq_n` has no effect while `irq_mask` is 1. When `irq_mask` is 0, a low `irq_n` is accepted, and it is not accepted a second time while the mask is set again.
- R7: Each falling edge on `nmi_n` causes exactly one non-maskable fetch, whatever the mask. Holding the input low does not repeat the fetch.
- R8: A one-cycle pulse on `swi_req` causes exactly one software-interrupt fetch.
- R9: When several sources are pending at once, they are served in the order reset, non-maskable, software, maskable.
- R10: Reset sets `irq_mask` to 1. Accepting any source sets it to 1. A pulse on `mask_clr` clears it when no source is accepted in that cycle.
- R11: A non-maskable edge or software pulse that arrives during a fetch is held pending and is served after that fetch ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| swi_req | input | 1 | Software interrupt pulse from decode |
| mask_clr | input | 1 | One-cycle strobe that clears the interrupt mask |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 16 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory has the data for the posted read |
| pc_load | output | 1 | One-cycle strobe: load pc_value into the program counter |
| pc_value | output | 16 | Assembled handler address |
| pc_src | output | 2 | Code of the source served (3 reset, 2 NMI, 1 SWI, 0 IRQ) |
| irq_mask | output | 1 | Interrupt mask flag |

## Verification
If the sequencer's phase register is wrong, the ports show it within one read. A read is issued to the wrong byte of the table, or the halves come back swapped in `pc_value` on the next load strobe. If a pending flag is lost or stuck, a fetch goes missing or appears twice in the scoreboard order. This shows by the following load strobe, or as a load with nothing expected. A wrong mask flag shows as a maskable fetch during a window where none may occur, or as no fetch after the clear strobe. The bench holds such windows for twenty cycles and counts load strobes.

// File: rtl/vfs_pkg.sv
// Package: shared types of the vector fetch sequencer.
// Assumes: source codes double as the table index (entry = base + 2*code).
package vfs_pkg;
    typedef enum logic [1:0] {
        SRC_IRQ = 2'd0,
        SRC_SWI = 2'd1,
        SRC_NMI = 2'd2,
        SRC_RST = 2'd3
    } vec_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_HI = 2'd1,
        ST_RD_LO = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/vfs_pend_latch.sv
// Module: pending-request flag. Set by a one-cycle event and cleared when the
// arbiter takes it. A set in the same cycle as a take wins, so no event is lost.
// Assumes: synchronous active-low reset; RST_VAL is the flag value in reset.
module vfs_pend_latch #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic take,
    output logic pend
);
    // Hold the request until it is served.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= RST_VAL;
        else        pend <= set_ev | (pend & ~take);
    end
endmodule

// File: rtl/vfs_nmi_edge.sv
// Module: falling-edge detector for the non-maskable input plus its pending flag.
// Assumes: nmi_n is already synchronous to clk; the previous value resets high.
module vfs_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);
    logic nmi_prev;
    logic fall;

    // Remember the last sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev <= 1'b1;
        else        nmi_prev <= nmi_n;
    end

    // One event per high-to-low transition.
    always_comb fall = nmi_prev & ~nmi_n;

    vfs_pend_latch #(.RST_VAL(1'b0)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (fall),
        .take   (take),
        .pend   (pend)
    );

    // R7: a detected edge is always recorded as pending.
    a_r7_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);
endmodule

// File: rtl/vfs_arbiter.sv
// Module: fixed-priority selector over the four sources.
// Assumes: irq_ok already combines the request level with the mask; grants only
// while the read engine is idle.
module vfs_arbiter
    import vfs_pkg::*;
(
    input  logic     idle,
    input  logic     rst_p,
    input  logic     nmi_p,
    input  logic     swi_p,
    input  logic     irq_ok,
    output logic     grant,
    output vec_src_e grant_src
);
    // Pick the highest pending source: reset, NMI, SWI, IRQ (R9).
    always_comb begin
        grant     = 1'b0;
        grant_src = SRC_RST;
        if (idle) begin
            if (rst_p) begin
                grant = 1'b1; grant_src = SRC_RST;
            end else if (nmi_p) begin
                grant = 1'b1; grant_src = SRC_NMI;
            end else if (swi_p) begin
                grant = 1'b1; grant_src = SRC_SWI;
            end else if (irq_ok) begin
                grant = 1'b1; grant_src = SRC_IRQ;
            end
        end
    end
endmodule

// File: rtl/vfs_read_fsm.sv
// Module: two-read engine. It reads the even byte (upper half), then the odd
// byte (lower half), of the selected table entry, and pulses pc_load once both are in.
// Assumes: the memory holds mem_rdata valid in the cycle mem_ready is high.
module vfs_read_fsm
    import vfs_pkg::*;
#(
    parameter int              DATA_W     = 8,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 16'hFFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  vec_src_e          start_src,
    output logic              idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output vec_src_e          pc_src
);
    localparam int VEC_W = 2 * DATA_W;

    fetch_state_e      state;
    logic [DATA_W-1:0] hi_byte;
    logic [ADDR_W-1:0] entry_addr;

    // Entry start address from the source code; the low bit selects the byte.
    always_comb begin
        entry_addr = TABLE_BASE + ADDR_W'({pc_src, 1'b0});
        idle       = (state == ST_IDLE);
        mem_req    = (state == ST_RD_HI) || (state == ST_RD_LO);
        mem_addr   = entry_addr | ADDR_W'(state == ST_RD_LO);
    end

    // Sequence the two reads and assemble the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pc_src   <= SRC_RST;
            hi_byte  <= '0;
            pc_load  <= 1'b0;
            pc_value <= '0;
        end else begin
            pc_load <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    pc_src <= start_src;
                    state  <= ST_RD_HI;
                end
                ST_RD_HI: if (mem_ready) begin
                    hi_byte <= mem_rdata;
                    state   <= ST_RD_LO;
                end
                ST_RD_LO: if (mem_ready) begin
                    pc_value <= ADDR_W'({hi_byte, mem_rdata});
                    pc_load  <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: a posted read is held until the memory answers.
    a_r4_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    // R3: a completed even-byte read is followed by the odd-byte read.
    a_r3_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_addr[0]) |=> (mem_req && mem_addr[0]));
    // R5: the load strobe lasts one cycle.
    a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);
    // R2: every read falls inside the vector table.
    a_r2_table_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr >= TABLE_BASE));
    // R5: no load strobe while a read is still posted.
    a_r5_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !mem_req || (mem_addr[0] == 1'b0));

    if (VEC_W != ADDR_W) begin : g_width_check
        initial $error("vector width must equal address width");
    end
endmodule

// File: rtl/vector_fetch_seq.sv
// Module: top of the reset/interrupt vector fetch sequencer. It holds the
// pending flags and the interrupt mask, arbitrates, and drives the read engine.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module vector_fetch_seq
    import vfs_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] TABLE_BASE = 16'hFFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              swi_req,
    input  logic              mask_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic [1:0]        pc_src,
    output logic              irq_mask
);
    logic     idle;
    logic     rst_p, nmi_p, swi_p, irq_ok;
    logic     grant;
    vec_src_e grant_src;
    vec_src_e served_src;
    logic     take_rst, take_nmi, take_swi;

    // Decode which pending flag the arbiter consumes this cycle.
    always_comb begin
        take_rst = grant && (grant_src == SRC_RST);
        take_nmi = grant && (grant_src == SRC_NMI);
        take_swi = grant && (grant_src == SRC_SWI);
        irq_ok   = ~irq_n & ~irq_mask;
        pc_src   = served_src;
    end

    // Reset vector request is armed by reset itself.
    vfs_pend_latch #(.RST_VAL(1'b1)) u_rst_pend (
        .clk (clk), .rst_n (rst_n), .set_ev (1'b0), .take (take_rst), .pend (rst_p)
    );

    vfs_nmi_edge u_nmi (
        .clk (clk), .rst_n (rst_n), .nmi_n (nmi_n), .take (take_nmi), .pend (nmi_p)
    );

    vfs_pend_latch #(.RST_VAL(1'b0)) u_swi_pend (
        .clk (clk), .rst_n (rst_n), .set_ev (swi_req), .take (take_swi), .pend (swi_p)
    );

    vfs_arbiter u_arb (
        .idle      (idle),
        .rst_p     (rst_p),
        .nmi_p     (nmi_p),
        .swi_p     (swi_p),
        .irq_ok    (irq_ok),
        .grant     (grant),
        .grant_src (grant_src)
    );

    vfs_read_fsm #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .TABLE_BASE (TABLE_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (grant),
        .start_src (grant_src),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .pc_src    (served_src)
    );

    // Interrupt mask: set by reset and on entry, cleared by the core's strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_mask <= 1'b1;
        else if (grant)    irq_mask <= 1'b1;
        else if (mask_clr) irq_mask <= 1'b0;
    end

    // R10: entering any source leaves the mask set.
    a_r10_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> irq_mask);
    // R6: while masked and nothing else pends, an idle engine issues no read.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && irq_mask && !rst_p && !nmi_p && !swi_p) |=> !mem_req);
    // R9: a pending NMI is never passed over for a lower source.
    a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && nmi_p && !rst_p) |=> (pc_src == SRC_NMI));
endmodule

// File: tb/vector_fetch_seq_bench.sv
// Bench: scoreboard of expected fetches against a wait-state memory model.
module vector_fetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        swi_req = 1'b0;
    logic        mask_clr = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ready = 1'b0;
    logic        pc_load;
    logic [15:0] pc_value;
    logic [1:0]  pc_src;
    logic        irq_mask;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    int req_cycles = 0;
    int wait_n = 0;
    int wcnt = 0;
    bit finished = 0;

    logic [7:0]  vmem [0:7];
    logic [17:0] exp_q [$];     // {src, pc}
    logic [15:0] addr_q [$];

    always #5 clk = ~clk;

    vector_fetch_seq u_vector_fetch_seq (
        .clk (clk), .rst_n (rst_n), .nmi_n (nmi_n), .irq_n (irq_n),
        .swi_req (swi_req), .mask_clr (mask_clr), .mem_req (mem_req),
        .mem_addr (mem_addr), .mem_rdata (mem_rdata), .mem_ready (mem_ready),
        .pc_load (pc_load), .pc_value (pc_value), .pc_src (pc_src),
        .irq_mask (irq_mask)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic fill_vec(input int seed);
        for (int i = 0; i < 8; i++) vmem[i] = 8'((seed * 29 + i * 53) ^ 8'hA5);
    endtask

    // Driver side: push the fetch the requirements predict.
    task automatic expect_fetch(input int src);
        exp_q.push_back({2'(src), vmem[2*src], vmem[2*src+1]});
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Memory model: answers each posted read after wait_n cycles.
    always @(negedge clk) begin
        if (!mem_req || !rst_n) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else begin
            if (mem_ready) wcnt = 0;
            if (wcnt >= wait_n) begin
                mem_ready = 1'b1;
                mem_rdata = (mem_addr >= 16'hFFF8) ? vmem[mem_addr[2:0]] : 8'h00;
                addr_q.push_back(mem_addr);
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end
    end

    // Monitor side: compare each load strobe with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && mem_req) req_cycles++;
        if (rst_n && pc_load) begin
            loads++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5: unexpected load actual 0x%0h expected none", pc_value);
            end else begin
                logic [17:0] e;
                logic [15:0] base;
                e = exp_q.pop_front();
                base = 16'hFFF8 + 16'(2 * int'(e[17:16]));
                check("R9 source order", int'(pc_src), int'(e[17:16]));
                check("R3 assembled address", int'(pc_value), int'(e[15:0]));
                if (addr_q.size() >= 2) begin
                    check("R2 even read address", int'(addr_q.pop_front()), int'(base));
                    check("R3 odd read address", int'(addr_q.pop_front()), int'(base + 16'd1));
                end else begin
                    check("R3 read count", addr_q.size(), 2);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int l0;
        fill_vec(1);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 mask in reset", int'(irq_mask), 1);
        check("R5 no load in reset", int'(pc_load), 0);
        check("R1 no read in reset", int'(mem_req), 0);

        // R1: reset vector fetched after release.
        expect_fetch(3);
        rst_n = 1'b1;
        wait_idle();
        check("R10 mask after reset fetch", int'(irq_mask), 1);

        // R6: masked level is ignored.
        fill_vec(2);
        l0 = loads;
        irq_n = 1'b0;
        req_cycles = 0;
        repeat (20) @(negedge clk);
        check("R6 no read while masked", req_cycles, 0);
        check("R6 no load while masked", loads, l0);
        // R6 unmasked level is taken once.
        expect_fetch(0);
        mask_clr = 1'b1; @(negedge clk); mask_clr = 1'b0;
        wait_idle();
        l0 = loads;
        repeat (20) @(negedge clk);
        check("R6 no repeat after entry", loads, l0);
        check("R10 mask set on entry", int'(irq_mask), 1);
        irq_n = 1'b1;
        mask_clr = 1'b1; @(negedge clk); mask_clr = 1'b0;
        check("R10 mask cleared by strobe", int'(irq_mask), 0);

        // R7: one fetch per edge with slow memory, level held low.
        fill_vec(3);
        wait_n = 3;
        l0 = loads;
        expect_fetch(2);
        nmi_n = 1'b0;
        wait_idle();
        repeat (30) @(negedge clk);
        check("R7 one fetch per edge", loads - l0, 1);
        nmi_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: software pulse.
        fill_vec(4);
        wait_n = 1;
        l0 = loads;
        expect_fetch(1);
        swi_req = 1'b1; @(negedge clk); swi_req = 1'b0;
        wait_idle();
        check("R8 one software fetch", loads - l0, 1);

        // R9/R11: requests arriving during a fetch are queued and ordered.
        fill_vec(5);
        wait_n = 4;
        expect_fetch(1);
        swi_req = 1'b1; @(negedge clk); swi_req = 1'b0;
        while (!mem_req) @(negedge clk);
        expect_fetch(2);
        expect_fetch(1);
        nmi_n = 1'b0; swi_req = 1'b1; mask_clr = 1'b1; irq_n = 1'b0;
        @(negedge clk);
        swi_req = 1'b0; mask_clr = 1'b0;
        wait_idle();
        l0 = loads;
        repeat (20) @(negedge clk);
        check("R11 masked IRQ stays blocked", loads, l0);
        expect_fetch(0);
        mask_clr = 1'b1; @(negedge clk); mask_clr = 1'b0;
        wait_idle();
        irq_n = 1'b1; nmi_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: reset outranks NMI and SWI present at release.
        fill_vec(6);
        wait_n = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        nmi_n = 1'b0;
        expect_fetch(3);
        expect_fetch(2);
        expect_fetch(1);
        rst_n = 1'b1; swi_req = 1'b1;
        @(negedge clk);
        swi_req = 1'b0;
        wait_idle();
        nmi_n = 1'b1;
        check("R5 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule